// File: doc/BRIEF.md
# Frame-Synchronized Shadow Register Bank

This block keeps two copies of an image sensor's readout configuration. A host loads a staging copy through a single-cycle register-write port. The readout sequencer uses an active copy. Staged values move into the active copy only on a one-cycle `frame_start` strobe, so a frame that is already being read out never sees a change in the middle of that frame.

The configuration is split into six groups: readout geometry, dark-row count, padding-row count, window, exposure and gain. Each group has a synchronization enable. While a group's enable is low, the group is frozen, so a host can spread a multi-register update over several frames and have all of it take effect in one frame. Some commits change the frame timing: a new readout geometry, dark-row count or padding-row count, and optionally a new window selection. After such a commit the block raises `frame_blank` for the next frame, so the output path can send training patterns in place of that frame. The gain output can be delayed by one extra frame so that gain changes line up with exposure changes.

The blanking decision is made by a two-state machine. In state `BL_LIVE`, `frame_blank` is low. In state `BL_BLANK`, `frame_blank` is high. The state changes only on a `frame_start` strobe:

- `LIVE_TO_BLANK`: a commit that causes blanking occurs while in `BL_LIVE`.
- `BLANK_TO_LIVE`: a frame starts with no such commit while in `BL_BLANK`.
- `BLANK_HOLD`: a new commit that causes blanking occurs while already in `BL_BLANK`.
- `LIVE_HOLD`: any other frame start while in `BL_LIVE`.

Top module: `frame_shadow_bank`

## Requirements
- R1: After reset, every staged and active field is zero, `frame_blank` is low, all six synchronization enables are high, and both the window-blank bit and the gain-delay bit are low.
- R2: A write to a configuration register does not change any output before the next `frame_start` strobe.
- R3: On a `frame_start` strobe, each enabled group copies its staged values to its active outputs, and they are visible in the following cycle.
- R4: While a group's enable bit is 0, its active values stay the same across any number of writes and frame starts, and the other enabled groups keep committing.
- R5: When a frozen group is enabled again, all of its staged fields, including those written in different frames, become active at the same next frame start.
- R6: A commit that changes the value of the readout group (address 0: skip mode [4:0], dark-row address [9:5], row offset [14:10]; address 1: last row [12:0]), the dark-row count (address 2, [7:0]) or the padding-row count (address 3, [7:0]) raises `frame_blank` for exactly the following frame. A commit of identical values does not raise it.
- R7: A change of the window selector (address 4, [2:0]) raises `frame_blank` for one frame only when the window-blank control bit (address 9, bit 8) is 1.
- R8: A change of the window width (address 5, [11:0]) or window height (address 6, [11:0]) takes effect at the frame start and never raises `frame_blank`.
- R9: An exposure commit (address 7, [15:0]) never raises `frame_blank`.
- R10: Gain (address 8, [7:0]) commits at frame start. When the gain-delay bit (address 9, bit 9) is 1, the `gain` output shows a committed value one frame later than it does when the bit is 0.
- R11: A write in the same cycle as `frame_start` is staged after that commit, and it becomes active at the following frame start.
- R12: The control register (address 9: group enables [5:0] in the order readout, dark, padding, window, exposure, gain) takes effect on the cycle after it is written. Writes to addresses 10 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle frame boundary strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| skip_mode | output | 5 | Active subsampling/binning mode |
| dark_row_addr | output | 5 | Active dark-row address |
| row_offset | output | 5 | Active vertical start offset |
| last_row | output | 13 | Active last-row address |
| dark_lines | output | 8 | Active dark-row count |
| pad_lines | output | 8 | Active padding-row count |
| win_sel | output | 3 | Active window selector |
| win_width | output | 12 | Active window width |
| win_height | output | 12 | Active window height |
| exposure | output | 16 | Active exposure |
| gain | output | 8 | Gain after optional frame delay |
| frame_blank | output | 1 | High for a frame that must be blanked |

## Verification
The bench targets the following corner cases. Each entry says what a faulty design would do.

- A design that commits on every write, instead of at the frame boundary, would show exposure values before `frame_start`.
- A design that ignores the group enables would let frozen exposure values through.
- A design that commits each register separately would split the readout-group update across two frames.
- A blank flag that does not compare values would blank a frame on an identical rewrite.
- A blank flag that does not clear would blank the second frame as well.
- A blank flag that treats any window write as a switch would blank a frame on a dimension change, or on a selector change while the window-blank bit is low.
- A gain delay that samples after the commit would show the new gain one frame early.
- A write that lands with the strobe and is not deferred would be committed in the same cycle.

// File: rtl/fsb_pkg.sv
`timescale 1ns/1ps
package fsb_pkg;
    localparam int NGRP    = 6;
    localparam int SKIP_W  = 5;
    localparam int DADR_W  = 5;
    localparam int ROFF_W  = 5;
    localparam int LAST_W  = 13;
    localparam int LCNT_W  = 8;
    localparam int WSEL_W  = 3;
    localparam int WDIM_W  = 12;
    localparam int EXP_W   = 16;
    localparam int GAIN_W  = 8;
    localparam int RD_LO_W = SKIP_W + DADR_W + ROFF_W;

    typedef enum logic [2:0] {
        GRP_READ = 3'd0, GRP_DARK = 3'd1, GRP_PAD = 3'd2,
        GRP_WIN  = 3'd3, GRP_EXP  = 3'd4, GRP_GAIN = 3'd5
    } grp_e;

    typedef enum logic {BL_LIVE = 1'b0, BL_BLANK = 1'b1} blank_st_e;

    localparam logic [3:0] ADR_RD_LO = 4'd0;
    localparam logic [3:0] ADR_RD_LAST = 4'd1;
    localparam logic [3:0] ADR_DARK = 4'd2;
    localparam logic [3:0] ADR_PAD = 4'd3;
    localparam logic [3:0] ADR_WSEL = 4'd4;
    localparam logic [3:0] ADR_WWID = 4'd5;
    localparam logic [3:0] ADR_WHGT = 4'd6;
    localparam logic [3:0] ADR_EXP = 4'd7;
    localparam logic [3:0] ADR_GAIN = 4'd8;
    localparam logic [3:0] ADR_CTL = 4'd9;
    localparam int CTL_BOS_BIT = 8;
    localparam int CTL_LAT_BIT = 9;

    function automatic int grp_w(int g);
        case (g)
            0:       return RD_LO_W + LAST_W;
            1, 2:    return LCNT_W;
            3:       return WSEL_W + 2 * WDIM_W;
            4:       return EXP_W;
            default: return GAIN_W;
        endcase
    endfunction

    function automatic int grp_off(int g);
        int s = 0;
        for (int i = 0; i < g; i++) s += grp_w(i);
        return s;
    endfunction

    localparam int TOT_W = grp_off(NGRP);
endpackage

// File: rtl/fsb_stage.sv
`timescale 1ns/1ps
module fsb_stage
    import fsb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [TOT_W-1:0]  stg,
    output logic [NGRP-1:0]   sync_en,
    output logic              blank_on_sw,
    output logic              gain_lat
);
    localparam int O_RD = grp_off(GRP_READ);
    localparam int O_WN = grp_off(GRP_WIN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg         <= '0;
            sync_en     <= '1;
            blank_on_sw <= 1'b0;
            gain_lat    <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_RD_LO:   stg[O_RD +: RD_LO_W] <= wr_data[RD_LO_W-1:0];
                ADR_RD_LAST: stg[O_RD + RD_LO_W +: LAST_W] <= wr_data[LAST_W-1:0];
                ADR_DARK:    stg[grp_off(GRP_DARK) +: LCNT_W] <= wr_data[LCNT_W-1:0];
                ADR_PAD:     stg[grp_off(GRP_PAD) +: LCNT_W] <= wr_data[LCNT_W-1:0];
                ADR_WSEL:    stg[O_WN +: WSEL_W] <= wr_data[WSEL_W-1:0];
                ADR_WWID:    stg[O_WN + WSEL_W +: WDIM_W] <= wr_data[WDIM_W-1:0];
                ADR_WHGT:    stg[O_WN + WSEL_W + WDIM_W +: WDIM_W] <= wr_data[WDIM_W-1:0];
                ADR_EXP:     stg[grp_off(GRP_EXP) +: EXP_W] <= wr_data[EXP_W-1:0];
                ADR_GAIN:    stg[grp_off(GRP_GAIN) +: GAIN_W] <= wr_data[GAIN_W-1:0];
                ADR_CTL: begin
                    sync_en     <= wr_data[NGRP-1:0];
                    blank_on_sw <= wr_data[CTL_BOS_BIT];
                    gain_lat    <= wr_data[CTL_LAT_BIT];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fsb_commit.sv
`timescale 1ns/1ps
module fsb_commit
    import fsb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [TOT_W-1:0] stg,
    input  logic [NGRP-1:0]  sync_en,
    output logic [TOT_W-1:0] act,
    output logic [NGRP-1:0]  chg
);
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int OFF = grp_off(g);
        localparam int W   = grp_w(g);
        logic [W-1:0] held;
        logic         take;

        assign take = frame_start && sync_en[g];

        always_ff @(posedge clk) begin
            if (!rst_n)    held <= '0;
            else if (take) held <= stg[OFF +: W];
        end

        assign act[OFF +: W] = held;
        assign chg[g]        = take && (stg[OFF +: W] != held);
    end
endmodule

// File: rtl/fsb_blank_fsm.sv
`timescale 1ns/1ps
module fsb_blank_fsm
    import fsb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_start,
    input  logic [NGRP-1:0] chg,
    input  logic            win_switch,
    input  logic            blank_on_sw,
    output logic            frame_blank
);
    blank_st_e state, state_nx;
    logic      cause;

    assign cause = chg[GRP_READ] || chg[GRP_DARK] || chg[GRP_PAD]
                || (win_switch && blank_on_sw);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= BL_LIVE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            BL_LIVE:  if (frame_start && cause) state_nx = BL_BLANK;
            BL_BLANK: if (frame_start)          state_nx = cause ? BL_BLANK : BL_LIVE;
        endcase
    end

    always_comb begin
        frame_blank = (state == BL_BLANK);
    end
endmodule

// File: rtl/fsb_gain_delay.sv
`timescale 1ns/1ps
module fsb_gain_delay #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_start,
    input  logic         gain_lat,
    input  logic [W-1:0] gain_act,
    output logic [W-1:0] gain_out
);
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (!rst_n)           prev <= '0;
        else if (frame_start) prev <= gain_act;
    end

    assign gain_out = gain_lat ? prev : gain_act;
endmodule

// File: rtl/frame_shadow_bank.sv
`timescale 1ns/1ps
module frame_shadow_bank
    import fsb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [SKIP_W-1:0] skip_mode,
    output logic [DADR_W-1:0] dark_row_addr,
    output logic [ROFF_W-1:0] row_offset,
    output logic [LAST_W-1:0] last_row,
    output logic [LCNT_W-1:0] dark_lines,
    output logic [LCNT_W-1:0] pad_lines,
    output logic [WSEL_W-1:0] win_sel,
    output logic [WDIM_W-1:0] win_width,
    output logic [WDIM_W-1:0] win_height,
    output logic [EXP_W-1:0]  exposure,
    output logic [GAIN_W-1:0] gain,
    output logic              frame_blank
);
    localparam int O_RD = grp_off(GRP_READ);
    localparam int O_WN = grp_off(GRP_WIN);

    logic [TOT_W-1:0] stg_flat, act_flat;
    logic [NGRP-1:0]  sync_en, chg;
    logic             blank_on_sw, gain_lat, win_switch;

    fsb_stage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .stg(stg_flat), .sync_en(sync_en),
        .blank_on_sw(blank_on_sw), .gain_lat(gain_lat)
    );

    fsb_commit u_commit (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .stg(stg_flat), .sync_en(sync_en), .act(act_flat), .chg(chg)
    );

    assign win_switch = frame_start && sync_en[GRP_WIN]
                     && (stg_flat[O_WN +: WSEL_W] != act_flat[O_WN +: WSEL_W]);

    fsb_blank_fsm u_blank (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .chg(chg),
        .win_switch(win_switch), .blank_on_sw(blank_on_sw),
        .frame_blank(frame_blank)
    );

    fsb_gain_delay #(.W(GAIN_W)) u_gain (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .gain_lat(gain_lat),
        .gain_act(act_flat[grp_off(GRP_GAIN) +: GAIN_W]),
        .gain_out(gain)
    );

    assign skip_mode     = act_flat[O_RD +: SKIP_W];
    assign dark_row_addr = act_flat[O_RD + SKIP_W +: DADR_W];
    assign row_offset    = act_flat[O_RD + SKIP_W + DADR_W +: ROFF_W];
    assign last_row      = act_flat[O_RD + RD_LO_W +: LAST_W];
    assign dark_lines    = act_flat[grp_off(GRP_DARK) +: LCNT_W];
    assign pad_lines     = act_flat[grp_off(GRP_PAD) +: LCNT_W];
    assign win_sel       = act_flat[O_WN +: WSEL_W];
    assign win_width     = act_flat[O_WN + WSEL_W +: WDIM_W];
    assign win_height    = act_flat[O_WN + WSEL_W + WDIM_W +: WDIM_W];
    assign exposure      = act_flat[grp_off(GRP_EXP) +: EXP_W];
endmodule

// File: rtl/fsb_checker.sv
`timescale 1ns/1ps
module fsb_checker
    import fsb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic [NGRP-1:0]   sync_en,
    input logic [NGRP-1:0]   chg,
    input logic              win_switch,
    input logic              blank_on_sw,
    input logic              gain_lat,
    input logic [EXP_W-1:0]  stg_exp,
    input logic [GAIN_W-1:0] stg_gain,
    input logic [EXP_W-1:0]  exposure,
    input logic [GAIN_W-1:0] gain,
    input logic              frame_blank
);
    p_exp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(exposure));

    p_exp_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && sync_en[GRP_EXP] |=> exposure == $past(stg_exp));

    p_exp_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && !sync_en[GRP_EXP] |=> $stable(exposure));

    p_blank_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(frame_blank));

    p_read_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && chg[GRP_READ] |=> frame_blank);

    p_no_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && !chg[GRP_READ] && !chg[GRP_DARK] && !chg[GRP_PAD]
        && !(win_switch && blank_on_sw) |=> !frame_blank);

    p_gain_direct_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && sync_en[GRP_GAIN] |=> gain_lat || gain == $past(stg_gain));
endmodule

bind frame_shadow_bank fsb_checker u_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .sync_en(sync_en),
    .chg(chg), .win_switch(win_switch), .blank_on_sw(blank_on_sw),
    .gain_lat(gain_lat),
    .stg_exp(stg_flat[fsb_pkg::grp_off(fsb_pkg::GRP_EXP) +: fsb_pkg::EXP_W]),
    .stg_gain(stg_flat[fsb_pkg::grp_off(fsb_pkg::GRP_GAIN) +: fsb_pkg::GAIN_W]),
    .exposure(exposure), .gain(gain), .frame_blank(frame_blank)
);

// File: tb/sim_frame_shadow_bank.sv
`timescale 1ns/1ps
module sim_frame_shadow_bank;
    logic clk = 1'b0, rst_n = 1'b0, fs = 1'b0, wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [4:0]  skip_mode, dark_row_addr, row_offset;
    logic [12:0] last_row;
    logic [7:0]  dark_lines, pad_lines, gain;
    logic [2:0]  win_sel;
    logic [11:0] win_width, win_height;
    logic [15:0] exposure;
    logic        frame_blank;
    int n_run = 0, n_fail = 0;
    bit done = 0;

    frame_shadow_bank u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(fs), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .skip_mode(skip_mode),
        .dark_row_addr(dark_row_addr), .row_offset(row_offset),
        .last_row(last_row), .dark_lines(dark_lines), .pad_lines(pad_lines),
        .win_sel(win_sel), .win_width(win_width), .win_height(win_height),
        .exposure(exposure), .gain(gain), .frame_blank(frame_blank)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic frame();
        fs = 1'b1;
        @(negedge clk);
        fs = 1'b0;
    endtask

    task automatic wr_at_frame(input logic [3:0] a, input logic [15:0] d);
        fs = 1'b1; wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        fs = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog got hang expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] prev_exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 skip", skip_mode, 0);      chk("R1 last", last_row, 0);
        chk("R1 dark", dark_lines, 0);     chk("R1 pad", pad_lines, 0);
        chk("R1 wsel", win_sel, 0);        chk("R1 wwid", win_width, 0);
        chk("R1 exp", exposure, 0);        chk("R1 gain", gain, 0);
        chk("R1 blank", frame_blank, 0);

        // R2 R3 R9 exposure sweep
        prev_exp = 16'h0;
        for (int i = 1; i <= 6; i++) begin
            logic [15:0] e;
            e = 16'(i * 4099);
            wr(4'd7, e);
            chk("R2 exp staged only", exposure, prev_exp);
            frame();
            chk("R3 exp committed", exposure, e);
            chk("R9 exp no blank", frame_blank, 0);
            prev_exp = e;
        end

        // R6 blank on readout, dark, pad groups
        for (int k = 0; k < 3; k++) begin
            logic [3:0] a;
            logic [7:0] v;
            a = (k == 0) ? 4'd0 : (k == 1) ? 4'd2 : 4'd3;
            v = 8'h11 + 8'(k);
            wr(a, {8'h0, v});
            frame();
            chk("R6 blank after change", frame_blank, 1);
            if (k == 0) chk("R6 skip", skip_mode, 5'h11);
            if (k == 1) chk("R6 dark", dark_lines, 8'h12);
            if (k == 2) chk("R6 pad", pad_lines, 8'h13);
            frame();
            chk("R6 blank one frame", frame_blank, 0);
            wr(a, {8'h0, v});
            frame();
            chk("R6 same value no blank", frame_blank, 0);
        end

        // R7 window switch
        wr(4'd4, 16'd3);
        frame();
        chk("R7 sel no bit", frame_blank, 0);
        chk("R7 sel value", win_sel, 3);
        wr(4'd9, 16'h013F);
        wr(4'd4, 16'd5);
        frame();
        chk("R7 sel with bit", frame_blank, 1);
        chk("R7 sel value2", win_sel, 5);
        frame();
        chk("R7 blank clears", frame_blank, 0);

        // R8 dimensions
        wr(4'd5, 16'h0280);
        wr(4'd6, 16'h01E0);
        frame();
        chk("R8 dim no blank", frame_blank, 0);
        chk("R8 width", win_width, 12'h280);
        chk("R8 height", win_height, 12'h1E0);

        // R4 freeze exposure, dark keeps committing
        wr(4'd9, 16'h012F);
        for (int j = 0; j < 3; j++) begin
            wr(4'd7, 16'h1111 * 16'(j + 1));
            wr(4'd2, 16'h0040 + 16'(j));
            frame();
            chk("R4 exp frozen", exposure, prev_exp);
            chk("R4 dark live", dark_lines, 8'h40 + 8'(j));
        end

        // R5 readout group across frames then release
        wr(4'd9, 16'h012E);
        wr(4'd0, 16'h0C41);
        frame();
        chk("R5 skip frozen", skip_mode, 5'h11);
        wr(4'd1, 16'h0ABC);
        frame();
        chk("R5 last frozen", last_row, 0);
        wr(4'd9, 16'h013F);
        chk("R12 ctl no commit", skip_mode, 5'h11);
        frame();
        chk("R5 skip", skip_mode, 1);
        chk("R5 dark addr", dark_row_addr, 2);
        chk("R5 row off", row_offset, 3);
        chk("R5 last", last_row, 13'h0ABC);
        chk("R5 exp released", exposure, 16'h3333);
        chk("R5 blank", frame_blank, 1);
        frame();

        // R11 write with strobe
        wr_at_frame(4'd7, 16'h7777);
        chk("R11 deferred", exposure, 16'h3333);
        frame();
        chk("R11 next frame", exposure, 16'h7777);

        // R12 unused addresses
        for (int a = 10; a < 16; a++) wr(4'(a), 16'hFFFF);
        frame();
        chk("R12 exp kept", exposure, 16'h7777);
        chk("R12 skip kept", skip_mode, 1);
        chk("R12 no blank", frame_blank, 0);

        // R10 gain latency
        wr(4'd8, 16'h005A);
        frame();
        chk("R10 gain direct", gain, 8'h5A);
        frame();
        wr(4'd9, 16'h033F);
        chk("R10 gain lat on", gain, 8'h5A);
        wr(4'd8, 16'h00A5);
        frame();
        chk("R10 gain delayed", gain, 8'h5A);
        frame();
        chk("R10 gain after delay", gain, 8'hA5);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule